// File: doc/BRIEF.md
# Segment Access Protection Checker

This block decides whether a single memory access may proceed through a cached segment descriptor. Each request carries an access kind, an access size, an offset into the segment, the descriptor's base, limit and attribute bits, the current privilege level and the protected-mode enable. One cycle later the block reports either success together with the linear address, or a fault code.

The checks run in a fixed priority order. A malformed request code or an access that runs past the segment limit is rejected first, in every mode. In protected mode only, a descriptor that is not present comes next. The privilege comparisons and the segment-type rules run last. Instruction fetches are not subject to the requested-privilege comparison.

The block sits between an address-generation stage and the memory port of a processor core. It holds no descriptor state of its own: the caller supplies the cached descriptor fields with every request.

Top module: `seg_guard`

## Requirements
- R1: While reset is asserted, and until the first response, rsp_valid, rsp_ok, rsp_fault and rsp_lin_addr are all zero.
- R2: A request with req_valid high at a rising edge produces rsp_valid high for exactly that next cycle. Back-to-back requests give back-to-back responses in the same order.
- R3: The access size code maps 0 to 1 byte, 1 to 2 bytes and 2 to 4 bytes. An access whose last byte (offset + bytes - 1) lies above seg_limit gives fault 1 (general protection), in both modes. The last-byte sum does not wrap: an access that passes the top of the address space always exceeds the limit.
- R4: With prot_en low, the present, executable, read/write, DPL, RPL and CPL inputs have no effect. An access within the limit succeeds.
- R5: With prot_en high and seg_present low, an access within the limit gives fault 2 (not present). A limit violation on the same access gives fault 1 instead.
- R6: The access kind code is 0 for a data read, 1 for a data write and 2 for an instruction fetch. In protected mode, a data read or write with RPL greater than DPL gives fault 1. A fetch ignores RPL.
- R7: In protected mode, any access kind with CPL greater than DPL gives fault 1. Equal levels pass.
- R8: In protected mode, a fetch from a segment whose executable bit is clear gives fault 1.
- R9: In protected mode, a data read from an executable segment whose read/write bit is clear gives fault 1. A read from an executable segment with the bit set passes. A read from a data segment passes whatever the bit holds.
- R10: In protected mode, a write to an executable segment gives fault 1. A write to a data segment whose read/write bit is clear gives fault 1.
- R11: A successful access reports rsp_ok high, rsp_fault 0 and rsp_lin_addr equal to seg_base + req_offset modulo 2^ADDR_W. A faulting access reports rsp_ok low and rsp_lin_addr zero.
- R12: Kind code 3 or size code 3 gives fault 1 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 four bytes, 3 reserved |
| req_offset | input | ADDR_W | Offset into the segment |
| seg_base | input | ADDR_W | Descriptor base address |
| seg_limit | input | ADDR_W | Highest valid byte offset |
| seg_present | input | 1 | Descriptor present bit |
| seg_exec | input | 1 | Segment is executable (code) |
| seg_rw | input | 1 | Readable for code, writable for data |
| seg_dpl | input | PRIV_W | Descriptor privilege level |
| seg_rpl | input | PRIV_W | Requested privilege level of the selector |
| cpl | input | PRIV_W | Current privilege level |
| prot_en | input | 1 | Protected-mode enable |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 not present |
| rsp_lin_addr | output | ADDR_W | Linear address on success, zero on fault |

## Verification
The bench builds the block with its defaults: ADDR_W of 32 and PRIV_W of 2. With the full 32-bit width, the vector table reaches two top-of-space cases: a base-plus-offset sum that wraps back to low addresses, and a four-byte access starting two bytes below the top of the address space. That access would pass a limit check whose sum wrapped, and it must still fault. The two-bit privilege width gives a real ordering among four levels, so the equal, greater and lesser cases of CPL, RPL and DPL can all be driven.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_FETCH = 2'd2,
      KIND_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GP   = 2'd1,
      FLT_NP   = 2'd2
   } fault_e;

   localparam int SIZE_CODE_W = 2;
   localparam int MAX_SIZE_LG = 2;

endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
   import seg_guard_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]      offset,
   input  logic [ADDR_W-1:0]      limit,
   input  logic [SIZE_CODE_W-1:0] size_code,
   output logic                   size_bad,
   output logic                   over
);
   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] span_m1;
   logic [EXT_W-1:0] last_byte;

   // bytes - 1 for each legal code; reserved code handled as one byte
   always_comb begin
      size_bad = (int'(size_code) > MAX_SIZE_LG);
      span_m1  = '0;
      if (!size_bad)
         span_m1 = (EXT_W'(1) << size_code) - EXT_W'(1);
   end

   // widened sum so the end of an access near the top never wraps
   assign last_byte = {1'b0, offset} + span_m1;
   assign over      = last_byte > {1'b0, limit};

endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
   import seg_guard_pkg::*;
#(
   parameter int PRIV_W = 2
) (
   input  logic [1:0]        kind,
   input  logic              prot_en,
   input  logic              present,
   input  logic              exec,
   input  logic              rw,
   input  logic [PRIV_W-1:0] dpl,
   input  logic [PRIV_W-1:0] rpl,
   input  logic [PRIV_W-1:0] cpl,
   output logic              kind_bad,
   output fault_e            fault
);
   acc_kind_e k;
   logic      priv_bad;
   logic      type_bad;

   assign k        = acc_kind_e'(kind);
   assign kind_bad = (k == KIND_RSVD);

   always_comb begin
      priv_bad = (cpl > dpl);
      if (k != KIND_FETCH && rpl > dpl)
         priv_bad = 1'b1;
   end

   always_comb begin
      unique case (k)
         KIND_FETCH: type_bad = !exec;
         KIND_READ:  type_bad = exec && !rw;
         KIND_WRITE: type_bad = exec || !rw;
         default:    type_bad = 1'b1;
      endcase
   end

   always_comb begin
      if (!prot_en)
         fault = FLT_NONE;
      else if (!present)
         fault = FLT_NP;
      else if (priv_bad || type_bad)
         fault = FLT_GP;
      else
         fault = FLT_NONE;
   end

endmodule

// File: rtl/seg_guard.sv
module seg_guard
   import seg_guard_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PRIV_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [ADDR_W-1:0] seg_base,
   input  logic [ADDR_W-1:0] seg_limit,
   input  logic              seg_present,
   input  logic              seg_exec,
   input  logic              seg_rw,
   input  logic [PRIV_W-1:0] seg_dpl,
   input  logic [PRIV_W-1:0] seg_rpl,
   input  logic [PRIV_W-1:0] cpl,
   input  logic              prot_en,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [1:0]        rsp_fault,
   output logic [ADDR_W-1:0] rsp_lin_addr
);
   generate
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr_w
         $error("seg_guard: ADDR_W out of range");
      end
      if (PRIV_W < 1 || PRIV_W > 4) begin : g_bad_priv_w
         $error("seg_guard: PRIV_W out of range");
      end
   endgenerate

   logic        size_bad;
   logic        limit_over;
   logic        kind_bad;
   fault_e      rights_fault;
   fault_e      fault_d;
   logic [ADDR_W-1:0] lin_d;

   seg_limit_chk #(.ADDR_W(ADDR_W)) u_limit (
      .offset    (req_offset),
      .limit     (seg_limit),
      .size_code (req_size),
      .size_bad  (size_bad),
      .over      (limit_over)
   );

   seg_rights_chk #(.PRIV_W(PRIV_W)) u_rights (
      .kind     (req_kind),
      .prot_en  (prot_en),
      .present  (seg_present),
      .exec     (seg_exec),
      .rw       (seg_rw),
      .dpl      (seg_dpl),
      .rpl      (seg_rpl),
      .cpl      (cpl),
      .kind_bad (kind_bad),
      .fault    (rights_fault)
   );

   // malformed codes and limit come before presence and rights
   always_comb begin
      if (kind_bad || size_bad || limit_over)
         fault_d = FLT_GP;
      else
         fault_d = rights_fault;
   end

   assign lin_d = seg_base + req_offset;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_ok       <= 1'b0;
         rsp_fault    <= FLT_NONE;
         rsp_lin_addr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault    <= fault_d;
            rsp_ok       <= (fault_d == FLT_NONE);
            rsp_lin_addr <= (fault_d == FLT_NONE) ? lin_d : '0;
         end
      end
   end

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid));

   // R3
   limit_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && limit_over) |=> (rsp_fault == FLT_GP && !rsp_ok));

   // R4
   real_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_en && !limit_over && !size_bad && !kind_bad) |=> rsp_ok);

   // R5
   not_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_en && !seg_present && !limit_over && !size_bad && !kind_bad)
      |=> (rsp_fault == FLT_NP));

   // R7
   cpl_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_en && cpl > seg_dpl) |=> (rsp_fault != FLT_NONE));

   // R11
   lin_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ok) |->
      (rsp_lin_addr == ADDR_W'($past(seg_base) + $past(req_offset))));

   // R11
   fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ok) |-> (rsp_lin_addr == '0 && rsp_fault != FLT_NONE));

   // R12
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == 2'd3 || req_size == 2'd3)) |=> (rsp_fault == FLT_GP));

endmodule

// File: tb/seg_guard_tb.sv
`timescale 1ns/1ps
module seg_guard_tb;
   localparam int AW = 32;
   localparam int PW = 2;
   localparam int NV = 24;
   localparam int VW = 112;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [1:0]    req_size = '0;
   logic [AW-1:0] req_offset = '0;
   logic [AW-1:0] seg_base = '0;
   logic [AW-1:0] seg_limit = '0;
   logic          seg_present = 1'b0;
   logic          seg_exec = 1'b0;
   logic          seg_rw = 1'b0;
   logic [PW-1:0] seg_dpl = '0;
   logic [PW-1:0] seg_rpl = '0;
   logic [PW-1:0] cpl = '0;
   logic          prot_en = 1'b0;
   logic          rsp_valid;
   logic          rsp_ok;
   logic [1:0]    rsp_fault;
   logic [AW-1:0] rsp_lin_addr;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   seg_guard #(.ADDR_W(AW), .PRIV_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_size(req_size), .req_offset(req_offset), .seg_base(seg_base),
      .seg_limit(seg_limit), .seg_present(seg_present), .seg_exec(seg_exec),
      .seg_rw(seg_rw), .seg_dpl(seg_dpl), .seg_rpl(seg_rpl), .cpl(cpl),
      .prot_en(prot_en), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
      .rsp_fault(rsp_fault), .rsp_lin_addr(rsp_lin_addr)
   );

   // row: kind size offset base limit p x rw dpl rpl cpl pe expected_fault
   localparam logic [VW-1:0] VEC [NV] = '{
      // R4 real mode ignores absent descriptor and privilege
      {2'd0,2'd2,32'h0000_0100,32'h0000_1000,32'h0000_FFFF,1'b0,1'b0,1'b0,2'd0,2'd3,2'd3,1'b0,2'd0},
      // R3 real mode end one past limit
      {2'd0,2'd2,32'h0000_FFFD,32'h0000_0000,32'h0000_FFFF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b0,2'd1},
      // R3 real mode exact fit
      {2'd0,2'd2,32'h0000_FFFC,32'h0000_0000,32'h0000_FFFF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b0,2'd0},
      // R3 protected byte at limit
      {2'd0,2'd0,32'h0000_FFFF,32'h0002_0000,32'h0000_FFFF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd0},
      // R5 not present
      {2'd0,2'd0,32'h0000_0010,32'h0000_0000,32'h0000_00FF,1'b0,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd2},
      // R5 limit beats not present
      {2'd0,2'd1,32'h0000_00FF,32'h0000_0000,32'h0000_00FF,1'b0,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R6 read rpl above dpl
      {2'd0,2'd0,32'h0000_0000,32'h0000_0000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd1,2'd2,2'd0,1'b1,2'd1},
      // R6 write rpl above dpl
      {2'd1,2'd0,32'h0000_0000,32'h0000_0000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd1,2'd2,2'd0,1'b1,2'd1},
      // R6 fetch ignores rpl
      {2'd2,2'd0,32'h0000_0008,32'h0000_4000,32'h0000_00FF,1'b1,1'b1,1'b0,2'd1,2'd3,2'd0,1'b1,2'd0},
      // R7 fetch cpl above dpl
      {2'd2,2'd0,32'h0000_0008,32'h0000_4000,32'h0000_00FF,1'b1,1'b1,1'b0,2'd0,2'd0,2'd1,1'b1,2'd1},
      // R7 read cpl above dpl
      {2'd0,2'd0,32'h0000_0008,32'h0000_4000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd1,2'd0,2'd2,1'b1,2'd1},
      // R8 fetch from data segment
      {2'd2,2'd0,32'h0000_0008,32'h0000_4000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R9 read from execute-only code
      {2'd0,2'd1,32'h0000_0020,32'h0000_8000,32'h0000_00FF,1'b1,1'b1,1'b0,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R9 read from readable code
      {2'd0,2'd1,32'h0000_0020,32'h0000_8000,32'h0000_00FF,1'b1,1'b1,1'b1,2'd0,2'd0,2'd0,1'b1,2'd0},
      // R9 read from read-only data
      {2'd0,2'd1,32'h0000_0022,32'h0000_8000,32'h0000_00FF,1'b1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b1,2'd0},
      // R10 write to code
      {2'd1,2'd1,32'h0000_0020,32'h0000_8000,32'h0000_00FF,1'b1,1'b1,1'b1,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R10 write to read-only data
      {2'd1,2'd1,32'h0000_0020,32'h0000_8000,32'h0000_00FF,1'b1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R10 write to writable data
      {2'd1,2'd2,32'h0000_0024,32'h0000_8000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd0},
      // R11 linear address wraps
      {2'd0,2'd2,32'h0000_0020,32'hFFFF_FFF0,32'hFFFF_FFFF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd0},
      // R3 access past top of address space
      {2'd0,2'd2,32'hFFFF_FFFE,32'h0000_0000,32'hFFFF_FFFF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R12 reserved size code
      {2'd0,2'd3,32'h0000_0000,32'h0000_0000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b0,2'd1},
      // R12 reserved kind code
      {2'd3,2'd0,32'h0000_0000,32'h0000_0000,32'h0000_00FF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd1},
      // R3 two bytes ending exactly at limit
      {2'd0,2'd1,32'h0000_00FE,32'h0000_0300,32'h0000_00FF,1'b1,1'b0,1'b1,2'd0,2'd0,2'd0,1'b1,2'd0},
      // R7 all levels equal at 3
      {2'd1,2'd2,32'h0000_0010,32'h0000_0500,32'h0000_00FF,1'b1,1'b0,1'b1,2'd3,2'd3,2'd3,1'b1,2'd0}
   };

   localparam int VREQ [NV] = '{4,3,3,3,5,5,6,6,6,7,7,8,9,9,9,10,10,10,11,3,12,12,3,7};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_row(input logic [VW-1:0] r);
      req_kind    = r[111:110];
      req_size    = r[109:108];
      req_offset  = r[107:76];
      seg_base    = r[75:44];
      seg_limit   = r[43:12];
      seg_present = r[11];
      seg_exec    = r[10];
      seg_rw      = r[9];
      seg_dpl     = r[8:7];
      seg_rpl     = r[6:5];
      cpl         = r[4:3];
      prot_en     = r[2];
   endtask

   task automatic check_resp(input string tag, input logic [1:0] ef, input logic [AW-1:0] elin);
      chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " fault"}, 64'(rsp_fault), 64'(ef));
      chk({tag, " ok"}, 64'(rsp_ok), 64'(ef == 2'd0));
      chk({tag, " lin"}, 64'(rsp_lin_addr), 64'(elin));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [AW-1:0] elin_a;
      logic [AW-1:0] elin_b;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid", 64'(rsp_valid), 64'd0);
      chk("R1 ok", 64'(rsp_ok), 64'd0);
      chk("R1 fault", 64'(rsp_fault), 64'd0);
      chk("R1 lin", 64'(rsp_lin_addr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 64'(rsp_valid), 64'd0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]    ef;
         logic [AW-1:0] el;
         string         tag;
         load_row(VEC[i]);
         req_valid = 1'b1;
         ef = VEC[i][1:0];
         el = (ef == 2'd0) ? (VEC[i][75:44] + VEC[i][107:76]) : '0;
         @(negedge clk);
         req_valid = 1'b0;
         tag = $sformatf("R%0d row%0d", VREQ[i], i);
         check_resp(tag, ef, el);
         @(negedge clk);
         // R2 single-cycle pulse
         chk($sformatf("R2 pulse row%0d", i), 64'(rsp_valid), 64'd0);
      end

      // R2 back-to-back requests keep order
      load_row(VEC[13]);
      req_valid = 1'b1;
      elin_a = 32'h0000_8020;
      @(negedge clk);
      check_resp("R2 b2b first", 2'd0, elin_a);
      load_row(VEC[4]);
      @(negedge clk);
      req_valid = 1'b0;
      check_resp("R2 b2b second", 2'd2, '0);
      load_row(VEC[17]);
      req_valid = 1'b1;
      elin_b = 32'h0000_8024;
      @(negedge clk);
      req_valid = 1'b0;
      check_resp("R2 b2b third", 2'd0, elin_b);
      @(negedge clk);
      chk("R2 b2b end", 64'(rsp_valid), 64'd0);

      // R1 reset with a request pending clears outputs
      load_row(VEC[0]);
      req_valid = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 mid-run valid", 64'(rsp_valid), 64'd0);
      chk("R1 mid-run lin", 64'(rsp_lin_addr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule